// File: doc/BRIEF.md
# Timekeeping Counters with Alarms

This block keeps three binary counters that run from a 256 Hz tick: a 40-bit real-time clock, a 40-bit interval timer and a 32-bit event counter. The real-time clock advances on every tick. The interval timer follows either a software run/halt bit or the activity of a single-wire data line. The event counter counts falling edges of that line, but only after the line has been high for long enough. A control register holds the oscillator enable, the timer mode, the delay select and the protect bits. A status register holds one alarm flag and one active-low interrupt enable per counter.

Each counter has an alarm register. When a counter advances onto the value in its alarm register, its flag sets. Reading the status register returns the flags and clears them. A `snap_i` pulse copies all three counters into holding registers, so a multi-byte read sees one consistent value. The line qualification delays are counted on a separate tick input, which lets a fast tick shorten them. The oscillator itself is outside this block. The protect permanence and the expiry lockout arrive here as the control bits and a `lock_i` input.

Byte map (5-bit address): 0 status, 1 control, 2..6 clock count, 7..11 interval count, 12..15 event count, 16..20 clock alarm, 21..25 interval alarm, 26..29 event alarm. All multi-byte values are little-endian.

Top module: `timekeep_alarm_unit`

## Requirements
- R1: After reset, all counters, alarms, status and control bits are 0 and `irq_no` is 1.
- R2: Counters change only while control bit 4 (oscillator enable) is 1. The clock count then advances by one on each cycle with `tick_i` high.
- R3: In manual mode (control bit 5 = 0), the interval count advances on each tick while control bit 6 is 0 and holds while it is 1.
- R4: In auto mode (control bit 5 = 1), the interval count starts advancing once `line_i` has been high for the qualification delay. It stops once `line_i` has been low for that delay. Control bit 6 has no effect in this mode.
- R5: The event count increments once on a falling edge of `line_i`, but only if the line was high for at least the qualification delay, counted in `qual_tick_i` pulses. Shorter high pulses are not counted.
- R6: Control bit 7 selects the delay: 1 selects DLY_LONG pulses and 0 selects DLY_SHORT pulses.
- R7: Status bits 0, 1 and 2 (clock, interval, event flags) set when their counter advances onto a value equal to its alarm. A status read returns the flags and clears them, and writes cannot change the flags.
- R8: `irq_no` is 0 while any flag is set whose enable (status bit 3, 4 or 5, same order) is 0. Otherwise it is 1.
- R9: A `snap_i` pulse captures all counters. Reads of count bytes return the captured value, which later ticks do not change.
- R10: Counter and alarm bytes at the map addresses can be written one byte at a time, and reads return data one cycle after `rd_en_i`.
- R11: Once any of control bits 0..2 is set, bits 0..3 freeze and bit 4 can only be set. Bit 0 blocks writes to the clock count and its alarm. Bit 1 blocks writes to the interval count, its alarm and bits 5..6. Bit 2 blocks writes to the event count, its alarm and bit 7.
- R12: While `lock_i` is 1, all register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 256 Hz count pulse, one cycle wide |
| qual_tick_i | input | 1 | Pulse that times the line qualification delay |
| line_i | input | 1 | Filtered, synchronous view of the data line |
| lock_i | input | 1 | Expiry lockout; blocks all writes |
| snap_i | input | 1 | Captures the counters into the holding registers |
| wr_en_i | input | 1 | Register byte write strobe |
| rd_en_i | input | 1 | Register byte read strobe |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The bench targets the qualification threshold from both sides. A high pulse shorter than the delay must leave the event counter unchanged, and a longer one must increment it. Both cases are repeated with the long delay selected, so a design that ignores the delay select, or compares against the wrong bound, would miscount. A tick arriving on the same cycle the line rises must not be counted in auto mode; a design that starts the timer on the raw line level would count it. The stop bit is toggled in auto mode, where a design that still obeys it would halt the timer.

The alarm tests check that a flag raises the interrupt only when its enable bit is 0, that a status read both reports and clears the flag, and that a written flag bit is dropped. A design with active-high enables, or with a clear that misses the read, would fail here. The protect and lock tests check that blocked writes leave the count, the protect bits and the oscillator bit unchanged, while unrelated fields stay writable.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int AW = 5;

  localparam int A_STAT    = 0;
  localparam int A_CTRL    = 1;
  localparam int A_RTC     = 2;
  localparam int A_ITV     = 7;
  localparam int A_CYC     = 12;
  localparam int A_RTC_ALM = 16;
  localparam int A_ITV_ALM = 21;
  localparam int A_CYC_ALM = 26;

  localparam int RTC_NB = 5;
  localparam int ITV_NB = 5;
  localparam int CYC_NB = 4;

  typedef struct packed {
    logic dsel;    // 7
    logic stop;    // 6
    logic auto_m;  // 5
    logic osc;     // 4
    logic ro;      // 3
    logic wpc;     // 2
    logic wpi;     // 1
    logic wpr;     // 0
  } ctrl_t;
endpackage

// File: rtl/tk_line_qual.sv
module tk_line_qual #(
  parameter int DLY_SHORT = 1,
  parameter int DLY_LONG  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic qual_tick_i,
  input  logic long_i,
  output logic fall_o,
  output logic run_o
);
  localparam int CW = $clog2(DLY_LONG + 1);

  logic [CW-1:0] hi_cnt_q, lo_cnt_q, thr;
  logic          line_q, run_q;

  assign thr = long_i ? CW'(DLY_LONG) : CW'(DLY_SHORT);

  // saturating run-length counters on each level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
      line_q   <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      line_q <= line_i;
      if (!line_i)                            hi_cnt_q <= '0;
      else if (qual_tick_i && hi_cnt_q < thr) hi_cnt_q <= hi_cnt_q + 1'b1;
      if (line_i)                             lo_cnt_q <= '0;
      else if (qual_tick_i && lo_cnt_q < thr) lo_cnt_q <= lo_cnt_q + 1'b1;
      if (line_i && hi_cnt_q >= thr)          run_q <= 1'b1;
      else if (!line_i && lo_cnt_q >= thr)    run_q <= 1'b0;
    end
  end

  assign fall_o = line_q & ~line_i & (hi_cnt_q >= thr);
  assign run_o  = run_q;

  // R5
  fall_after_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!line_i && $past(line_i)));
  // R4
  run_start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(line_i));
  // R4
  run_stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> !$past(line_i));
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int NB = 5,
  localparam int W = 8 * NB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic [NB-1:0] cnt_we_i,
  input  logic [NB-1:0] alm_we_i,
  input  logic [7:0]    wdata_i,
  input  logic          snap_i,
  output logic [W-1:0]  hold_o,
  output logic [W-1:0]  alm_o,
  output logic          hit_o
);
  logic [W-1:0] cnt_q, cnt_d, alm_q, alm_d, hold_q, cnt_nx;

  assign cnt_nx = cnt_q + W'(1);

  always_comb begin
    cnt_d = inc_i ? cnt_nx : cnt_q;
    alm_d = alm_q;
    for (int b = 0; b < NB; b++) begin
      if (cnt_we_i[b]) cnt_d[8*b +: 8] = wdata_i;
      if (alm_we_i[b]) alm_d[8*b +: 8] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      alm_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      alm_q <= alm_d;
      if (snap_i) hold_q <= cnt_q;
    end
  end

  // alarm fires on the step onto the alarm value, not while parked on it
  assign hit_o  = inc_i && (cnt_we_i == '0) && (cnt_nx == alm_q);
  assign hold_o = hold_q;
  assign alm_o  = alm_q;

  // R2
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && cnt_we_i == '0) |=> $stable(cnt_q));
  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(hold_q));
endmodule

// File: rtl/timekeep_alarm_unit.sv
module timekeep_alarm_unit #(
  parameter int DLY_SHORT = 1,
  parameter int DLY_LONG  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       qual_tick_i,
  input  logic       line_i,
  input  logic       lock_i,
  input  logic       snap_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [4:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_no
);
  import tk_pkg::*;

  localparam int RTC_W = 8 * RTC_NB;
  localparam int ITV_W = 8 * ITV_NB;
  localparam int CYC_W = 8 * CYC_NB;

  ctrl_t ctrl_q, ctrl_wr, ctrl_d;
  logic [2:0] flag_q, ien_q, hit;
  logic       wr_ok, wp_any, stat_rd, fall, run;
  logic       rtc_inc, itv_inc, cyc_inc;
  logic [RTC_NB-1:0] rtc_we, rtc_awe;
  logic [ITV_NB-1:0] itv_we, itv_awe;
  logic [CYC_NB-1:0] cyc_we, cyc_awe;
  logic [RTC_W-1:0]  rtc_hold, rtc_alm;
  logic [ITV_W-1:0]  itv_hold, itv_alm;
  logic [CYC_W-1:0]  cyc_hold, cyc_alm;
  logic [7:0]        rd_mux, rdata_q;
  int                a;

  assign a       = int'(addr_i);
  assign wr_ok   = wr_en_i & ~lock_i;
  assign wp_any  = ctrl_q.wpr | ctrl_q.wpi | ctrl_q.wpc;
  assign stat_rd = rd_en_i && (a == A_STAT);

  tk_line_qual #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .qual_tick_i(qual_tick_i),
    .long_i(ctrl_q.dsel), .fall_o(fall), .run_o(run)
  );

  assign rtc_inc = tick_i & ctrl_q.osc;
  assign itv_inc = tick_i & ctrl_q.osc & (ctrl_q.auto_m ? run : ~ctrl_q.stop);
  assign cyc_inc = fall & ctrl_q.osc;

  // byte strobes, gated by lock and per-counter protect
  always_comb begin
    for (int i = 0; i < RTC_NB; i++) begin
      rtc_we[i]  = wr_ok && !ctrl_q.wpr && (a == A_RTC + i);
      rtc_awe[i] = wr_ok && !ctrl_q.wpr && (a == A_RTC_ALM + i);
    end
    for (int i = 0; i < ITV_NB; i++) begin
      itv_we[i]  = wr_ok && !ctrl_q.wpi && (a == A_ITV + i);
      itv_awe[i] = wr_ok && !ctrl_q.wpi && (a == A_ITV_ALM + i);
    end
    for (int i = 0; i < CYC_NB; i++) begin
      cyc_we[i]  = wr_ok && !ctrl_q.wpc && (a == A_CYC + i);
      cyc_awe[i] = wr_ok && !ctrl_q.wpc && (a == A_CYC_ALM + i);
    end
  end

  tk_counter #(.NB(RTC_NB)) u_rtc (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(rtc_inc), .cnt_we_i(rtc_we),
    .alm_we_i(rtc_awe), .wdata_i(wdata_i), .snap_i(snap_i),
    .hold_o(rtc_hold), .alm_o(rtc_alm), .hit_o(hit[0])
  );
  tk_counter #(.NB(ITV_NB)) u_itv (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(itv_inc), .cnt_we_i(itv_we),
    .alm_we_i(itv_awe), .wdata_i(wdata_i), .snap_i(snap_i),
    .hold_o(itv_hold), .alm_o(itv_alm), .hit_o(hit[1])
  );
  tk_counter #(.NB(CYC_NB)) u_cyc (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(cyc_inc), .cnt_we_i(cyc_we),
    .alm_we_i(cyc_awe), .wdata_i(wdata_i), .snap_i(snap_i),
    .hold_o(cyc_hold), .alm_o(cyc_alm), .hit_o(hit[2])
  );

  // control write with protect rules
  always_comb begin
    ctrl_wr = ctrl_t'(wdata_i);
    ctrl_d  = ctrl_q;
    if (wr_ok && a == A_CTRL) begin
      if (!wp_any) begin
        ctrl_d = ctrl_wr;
      end else begin
        ctrl_d.osc = ctrl_q.osc | ctrl_wr.osc;
        if (!ctrl_q.wpi) begin
          ctrl_d.auto_m = ctrl_wr.auto_m;
          ctrl_d.stop   = ctrl_wr.stop;
        end
        if (!ctrl_q.wpc) ctrl_d.dsel = ctrl_wr.dsel;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flag_q  <= '0;
      ien_q   <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= (stat_rd ? 3'b000 : flag_q) | hit;
      if (wr_ok && a == A_STAT) ien_q <= wdata_i[5:3];
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (a == A_STAT)                                rd_mux = {2'b00, ien_q, flag_q};
    else if (a == A_CTRL)                           rd_mux = ctrl_q;
    else if (a >= A_RTC && a < A_RTC + RTC_NB)      rd_mux = rtc_hold[8*(a-A_RTC) +: 8];
    else if (a >= A_ITV && a < A_ITV + ITV_NB)      rd_mux = itv_hold[8*(a-A_ITV) +: 8];
    else if (a >= A_CYC && a < A_CYC + CYC_NB)      rd_mux = cyc_hold[8*(a-A_CYC) +: 8];
    else if (a >= A_RTC_ALM && a < A_RTC_ALM + RTC_NB) rd_mux = rtc_alm[8*(a-A_RTC_ALM) +: 8];
    else if (a >= A_ITV_ALM && a < A_ITV_ALM + ITV_NB) rd_mux = itv_alm[8*(a-A_ITV_ALM) +: 8];
    else if (a >= A_CYC_ALM && a < A_CYC_ALM + CYC_NB) rd_mux = cyc_alm[8*(a-A_CYC_ALM) +: 8];
  end

  assign rdata_o = rdata_q;
  assign irq_no  = ~|(flag_q & ~ien_q);

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && hit == 3'b000) |=> (flag_q == 3'b000));
  // R7
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == 3'b000) |=> ((flag_q & ~$past(flag_q)) == 3'b000));
  // R11
  wp_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_any |=> ($stable(ctrl_q[3:0]) && !$fell(ctrl_q.osc)));
  // R12
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(ctrl_q) && $stable(ien_q)));
endmodule

// File: tb/timekeep_alarm_unit_bench.sv
module timekeep_alarm_unit_bench;
  localparam int SH = 4;
  localparam int LG = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, qual = 1, line = 0, lock = 0, snap = 0, wr = 0, rd = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  timekeep_alarm_unit #(.DLY_SHORT(SH), .DLY_LONG(LG)) u_timekeep_alarm_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .qual_tick_i(qual), .line_i(line),
    .lock_i(lock), .snap_i(snap), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_n)
  );

  typedef struct packed { logic [4:0] a; logic [7:0] d; logic [7:0] e; logic [3:0] r; } vec_t;
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{5'd16, 8'h11, 8'h11, 4'd10}, '{5'd17, 8'h22, 8'h22, 4'd10}, // R10 clock alarm
    '{5'd18, 8'h33, 8'h33, 4'd10}, '{5'd19, 8'h44, 8'h44, 4'd10},
    '{5'd20, 8'h55, 8'h55, 4'd10},
    '{5'd21, 8'hA1, 8'hA1, 4'd10}, '{5'd22, 8'hB2, 8'hB2, 4'd10}, // R10 interval alarm
    '{5'd23, 8'hC3, 8'hC3, 4'd10}, '{5'd24, 8'hD4, 8'hD4, 4'd10},
    '{5'd25, 8'hE5, 8'hE5, 4'd10},
    '{5'd26, 8'h9C, 8'h9C, 4'd10}, '{5'd27, 8'h8B, 8'h8B, 4'd10}, // R10 event alarm
    '{5'd28, 8'h7A, 8'h7A, 4'd10}, '{5'd29, 8'h69, 8'h69, 4'd10},
    '{5'd0,  8'h38, 8'h38, 4'd8},                                 // R8 enables writable
    '{5'd0,  8'h07, 8'h00, 4'd7},                                 // R7 flag bits not writable
    '{5'd1,  8'h00, 8'h00, 4'd1}
  };

  task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input int a_, input logic [7:0] d_);
    @(negedge clk); addr = 5'(a_); wdata = d_; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input int a_, output logic [7:0] v);
    @(negedge clk); addr = 5'(a_); rd = 1;
    @(negedge clk); rd = 0; v = rdata;
  endtask

  task automatic rcnt(input int base, input int nb, output logic [63:0] v);
    logic [7:0] b;
    v = '0;
    for (int i = 0; i < nb; i++) begin
      rreg(base + i, b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic do_snap();
    @(negedge clk); snap = 1;
    @(negedge clk); snap = 0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); line = 1;
    repeat (n) @(negedge clk);
    line = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [63:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(1, irq_n, 1);
    rreg(0, v); check(1, v, 8'h00);
    rreg(1, v); check(1, v, 8'h00);
    do_snap(); rcnt(2, 5, c); check(1, c, 0);

    for (int k = 0; k < NV; k++) begin
      wreg(VECS[k].a, VECS[k].d);
      rreg(VECS[k].a, v);
      check(VECS[k].r, v, VECS[k].e);
    end

    // R2 no counting with oscillator off
    ticks(3); pulse(6); do_snap();
    rcnt(2, 5, c); check(2, c, 0);
    rcnt(12, 4, c); check(2, c, 0);

    // R2 / R3 manual mode running
    wreg(1, 8'h10); ticks(5); do_snap();
    rcnt(2, 5, c); check(2, c, 5);
    rcnt(7, 5, c); check(3, c, 5);
    // R3 halted
    wreg(1, 8'h50); ticks(4); do_snap();
    rcnt(2, 5, c); check(2, c, 9);
    rcnt(7, 5, c); check(3, c, 5);

    // R4 auto mode
    wreg(1, 8'h30); ticks(2);
    @(negedge clk); line = 1; tick = 1;
    @(negedge clk); tick = 0;
    do_snap(); rcnt(7, 5, c); check(4, c, 5);
    repeat (6) @(negedge clk);
    ticks(3); do_snap(); rcnt(7, 5, c); check(4, c, 8);
    wreg(1, 8'h70); ticks(2); do_snap(); rcnt(7, 5, c); check(4, c, 10);
    @(negedge clk); line = 0;
    repeat (8) @(negedge clk);
    ticks(3); do_snap(); rcnt(7, 5, c); check(4, c, 10);
    rcnt(12, 4, c); check(5, c, 1);

    // R5 qualification, short delay
    wreg(1, 8'h10);
    pulse(2); do_snap(); rcnt(12, 4, c); check(5, c, 1);
    pulse(6); do_snap(); rcnt(12, 4, c); check(5, c, 2);
    // R6 long delay
    wreg(1, 8'h90);
    pulse(6);  do_snap(); rcnt(12, 4, c); check(6, c, 2);
    pulse(14); do_snap(); rcnt(12, 4, c); check(6, c, 3);

    // R9 snapshot holds across ticks
    do_snap(); rreg(2, v); check(9, v, 8'd20);
    ticks(2); rreg(2, v); check(9, v, 8'd20);
    do_snap(); rreg(2, v); check(9, v, 8'd22);

    // R10 byte write of live count
    wreg(1, 8'h10);
    wreg(3, 8'h12); wreg(2, 8'h00); do_snap();
    rcnt(2, 5, c); check(10, c, 64'h1200);

    // R7 / R8 clock alarm with enable active
    wreg(0, 8'h00);
    for (int i = 0; i < 5; i++) wreg(2 + i, 8'h00);
    wreg(16, 8'h03); for (int i = 1; i < 5; i++) wreg(16 + i, 8'h00);
    ticks(2); check(8, irq_n, 1);
    ticks(1); check(8, irq_n, 0);
    rreg(0, v); check(7, v, 8'h01);
    check(8, irq_n, 1);
    rreg(0, v); check(7, v, 8'h00);
    // R8 masked
    wreg(0, 8'h08);
    for (int i = 0; i < 5; i++) wreg(2 + i, 8'h00);
    ticks(3); check(8, irq_n, 1);
    rreg(0, v); check(7, v, 8'h09);
    // R7 event alarm
    wreg(0, 8'h00);
    for (int i = 0; i < 4; i++) wreg(12 + i, 8'h00);
    wreg(26, 8'h01); for (int i = 1; i < 4; i++) wreg(26 + i, 8'h00);
    pulse(6); check(8, irq_n, 0);
    rreg(0, v); check(7, v, 8'h04);

    // R11 protect
    wreg(1, 8'h11); rreg(1, v); check(11, v, 8'h11);
    wreg(1, 8'h00); rreg(1, v); check(11, v, 8'h11);
    do_snap(); rcnt(2, 5, c);
    wreg(2, 8'h77); do_snap(); rreg(2, v); check(11, v, c[7:0]);
    wreg(7, 8'h44); do_snap(); rreg(7, v); check(11, v, 8'h44);
    wreg(1, 8'h31); rreg(1, v); check(11, v, 8'h31);

    // R12 lock
    lock = 1;
    wreg(0, 8'h38); rreg(0, v); check(12, v, 8'h00);
    wreg(26, 8'hEE); rreg(26, v); check(12, v, 8'h01);
    lock = 0;

    finish_run();
  end
endmodule